// File: doc/BRIEF.md
# Watchdog Timer with Key-Protected Setup and NMI Pulse

This block is a watchdog timer that sits on a simple 16-bit register bus with per-byte write strobes. A 32-bit up-counter runs while the run bit is set. When the counter equals a 32-bit match value, it returns to zero on the next clock and keeps counting. The same match raises the watchdog event. If the NMI enable bit is set, the event shows up as a one-cycle internal NMI request. It also drives an active-low external NMI line low for a fixed 32 clock cycles. Software has to restart the count through the control register before the match is reached, or the event fires.

The setup register and both halves of the match value are protected against stray writes. A full 16-bit write of 0x0096 to the key register unlocks them. Any other full-width write locks them again. While the block is locked, writes to the protected registers complete on the bus but change nothing. The counter value can be read back as two 16-bit halves.

Registers are selected by a 3-bit word index: 0 key, 1 setup, 2 match low, 3 match high, 4 count low, 5 count high, 6 control. Reads are combinational from the index. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `wdt_nmi_core`

## Requirements
- R1: After reset, nmi_n is 1 and nmi_req is 0. The counter reads 0 and is stopped. The setup register (index 1) reads 0, the match value reads 0, and the block is locked.
- R2: While setup bit 0 (run) is 1, the counter rises by one per clock. In the clock after it equals the match value it reads 0, so it repeats every match+1 clocks.
- R3: When a match occurs and setup bit 1 (NMI enable) is 1, nmi_req is 1 for exactly one cycle. In the same cycle nmi_n goes low and stays low for exactly 32 cycles.
- R4: A write to index 0 with both byte strobes set and data 0x0096 unlocks the protected registers. A full-width write of any other value locks them. The unlocked state lasts across any number of writes.
- R5: While locked, writes to index 1 (setup), index 2 (match bits 15:0) and index 3 (match bits 31:16) leave those registers unchanged.
- R6: Index 0 always reads 0. A write to index 0 with only one byte strobe set does not change the lock state.
- R7: On the setup and match registers, strobe bit 0 enables writing data bits 7:0 and strobe bit 1 enables data bits 15:8. Bytes whose strobe is clear keep their old value.
- R8: A write to index 6 with strobe bit 0 set and data bit 0 set makes the counter read 0 on the next clock. This takes priority over counting.
- R9: With NMI enable at 0, nmi_req stays 0 and nmi_n stays 1, while the counter still wraps at the match value.
- R10: A match that arrives while nmi_n is already low restarts the pulse, so nmi_n stays low until 32 cycles after the latest match.
- R11: The counter reads back as bits 15:0 at index 4 and bits 31:16 at index 5. Clearing the run bit freezes the counter at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte strobes: bit 0 for data bits 7:0, bit 1 for data bits 15:8 |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| nmi_req | output | 1 | One-cycle internal NMI request on an enabled match |
| nmi_n | output | 1 | Active-low external NMI pulse, 32 cycles long |

## Verification
The assertions assume that the bus inputs are stable and free of X while the synchronised reset is released. They also assume that a single write carries one register index, so a key change and a protected write never occur in the same cycle. The bench drives every input at the falling clock edge and holds it across the next rising edge. It issues one write per cycle and returns bus_wr and the strobes to zero between writes. Random match values are kept between 10 and 59 so that single-hit, overlapping and back-to-back pulse patterns all occur within short runs. The pulse length and the counter wrap are checked cycle by cycle against a bench model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_KEY      = 3'd0,
    IDX_SETUP    = 3'd1,
    IDX_MATCH_LO = 3'd2,
    IDX_MATCH_HI = 3'd3,
    IDX_COUNT_LO = 3'd4,
    IDX_COUNT_HI = 3'd5,
    IDX_CTRL     = 3'd6
  } reg_idx_e;

  localparam logic [15:0] UNLOCK_KEY = 16'h0096;
  localparam int unsigned SETUP_W       = 2;
  localparam int unsigned SETUP_RUN_BIT = 0;
  localparam int unsigned SETUP_NMI_BIT = 1;
  localparam int unsigned CTRL_RESTART_BIT = 0;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   be,
  output logic                  run,
  output logic                  nmi_en,
  output logic                  unlocked,
  output logic                  restart,
  output logic [CNT_W-1:0]      match
);
  localparam int unsigned NBYTE = DATA_W / 8;
  localparam int unsigned NHALF = CNT_W / DATA_W;

  logic [DATA_W-1:0]  bmask;
  logic               unlocked_q, unlocked_d;
  logic [SETUP_W-1:0] setup_q, setup_d;
  logic [CNT_W-1:0]   match_q, match_d;
  logic               key_wr, prot_wr;

  // expand byte strobes into a bit mask
  for (genvar g = 0; g < NBYTE; g++) begin : g_mask
    assign bmask[g*8 +: 8] = {8{be[g]}};
  end

  assign key_wr  = wr && (addr == IDX_KEY) && (&be);
  assign prot_wr = wr && unlocked_q;

  always_comb begin
    unlocked_d = unlocked_q;
    setup_d    = setup_q;
    match_d    = match_q;
    if (key_wr) begin
      unlocked_d = (wdata == UNLOCK_KEY);
    end
    if (prot_wr && (addr == IDX_SETUP)) begin
      setup_d = (setup_q & ~bmask[SETUP_W-1:0]) | (wdata[SETUP_W-1:0] & bmask[SETUP_W-1:0]);
    end
    for (int h = 0; h < NHALF; h++) begin
      if (prot_wr && (addr == ADDR_W'(int'(IDX_MATCH_LO) + h))) begin
        match_d[h*DATA_W +: DATA_W] = (match_q[h*DATA_W +: DATA_W] & ~bmask) | (wdata & bmask);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      setup_q    <= '0;
      match_q    <= '0;
    end else begin
      unlocked_q <= unlocked_d;
      setup_q    <= setup_d;
      match_q    <= match_d;
    end
  end

  assign run      = setup_q[SETUP_RUN_BIT];
  assign nmi_en   = setup_q[SETUP_NMI_BIT];
  assign unlocked = unlocked_q;
  assign match    = match_q;
  assign restart  = wr && (addr == IDX_CTRL) && be[0] && wdata[CTRL_RESTART_BIT];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign hit = run && (cnt_q == match);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || hit) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic nmi_n,
  output logic nmi_req
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;
  logic          nmi_n_q, nmi_n_d;
  logic          req_q;

  always_comb begin
    left_d = left_q;
    if (fire) begin
      left_d = PW'(PULSE_LEN);
    end else if (left_q != '0) begin
      left_d = left_q - PW'(1);
    end
    nmi_n_d = (left_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      nmi_n_q <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      left_q  <= left_d;
      nmi_n_q <= nmi_n_d;
      req_q   <= fire;
    end
  end

  assign nmi_n   = nmi_n_q;
  assign nmi_req = req_q;
endmodule

// File: rtl/wdt_nmi_core.sv
module wdt_nmi_core
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PULSE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [1:0]        bus_be,
  output logic [15:0]       bus_rdata,
  output logic              nmi_req,
  output logic              nmi_n
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             run, nmi_en, unlocked, restart, hit;
  logic [CNT_W-1:0] match, cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .run      (run),
    .nmi_en   (nmi_en),
    .unlocked (unlocked),
    .restart  (restart),
    .match    (match)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .restart (restart),
    .match   (match),
    .cnt     (cnt),
    .hit     (hit)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (hit && nmi_en),
    .nmi_n   (nmi_n),
    .nmi_req (nmi_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IDX_SETUP:    bus_rdata[SETUP_W-1:0] = {nmi_en, run};
      IDX_MATCH_LO: bus_rdata = match[DATA_W-1:0];
      IDX_MATCH_HI: bus_rdata = match[CNT_W-1:DATA_W];
      IDX_COUNT_LO: bus_rdata = cnt[DATA_W-1:0];
      IDX_COUNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_nmi_chk.sv
module wdt_nmi_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic [1:0]       bus_be,
  input logic [15:0]      bus_rdata,
  input logic             unlocked,
  input logic             run,
  input logic             nmi_en,
  input logic [CNT_W-1:0] match,
  input logic [CNT_W-1:0] cnt,
  input logic             hit,
  input logic             nmi_n,
  input logic             nmi_req
);
  logic prot_access, ctrl_restart;
  assign prot_access  = bus_wr && (bus_addr == IDX_SETUP || bus_addr == IDX_MATCH_LO ||
                                   bus_addr == IDX_MATCH_HI);
  assign ctrl_restart = bus_wr && (bus_addr == IDX_CTRL) && bus_be[0] && bus_wdata[0];

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!unlocked && prot_access) |=> ($stable(match) && $stable(run) && $stable(nmi_en))); // R5
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == IDX_KEY) |-> (bus_rdata == 16'h0000)); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |=> (cnt == '0)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_restart |=> (cnt == '0)); // R8
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && nmi_en) |=> (!nmi_n && nmi_req)); // R3
  AST_NMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(nmi_req) |-> $past(nmi_en)); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !ctrl_restart) |=> $stable(cnt)); // R11
endmodule

bind wdt_nmi_core wdt_nmi_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_be     (bus_be),
  .bus_rdata  (bus_rdata),
  .unlocked   (unlocked),
  .run        (run),
  .nmi_en     (nmi_en),
  .match      (match),
  .cnt        (cnt),
  .hit        (hit),
  .nmi_n      (nmi_n),
  .nmi_req    (nmi_req)
);

// File: tb/tb_wdt_nmi_core.sv
module tb_wdt_nmi_core;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0]  bus_be;
  logic [15:0] bus_rdata;
  logic        nmi_req, nmi_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_match = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_nmi_core dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .nmi_req(nmi_req), .nmi_n(nmi_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic bread(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdcnt(output logic [31:0] c);
    logic [15:0] lo, hi;
    bread(3'd4, lo);
    bread(3'd5, hi);
    c = {hi, lo};
  endtask

  // expected nmi_n low at cycle k after start for match m
  function automatic bit model_low(int k, int m, bit en);
    bit low = 1'b0;
    if (!en) return 1'b0;
    for (int j = 1; j * (m + 1) <= k; j++)
      if (k - j * (m + 1) < PULSE) low = 1'b1;
    return low;
  endfunction

  task automatic run_model(input int m, input bit en, input int ncyc, input string req);
    logic [31:0] c;
    int bad_c = 0, bad_n = 0, bad_r = 0;
    logic [31:0] ac = 0, ec = 0;
    logic an = 0, en_exp = 0, ar = 0, er = 0;
    bwrite(3'd2, m[15:0], 2'b11);
    bwrite(3'd3, m[31:16], 2'b11);
    bwrite(3'd1, {14'b0, en, 1'b1}, 2'b11);
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      rdcnt(c);
      if (c !== 32'(k % (m + 1))) begin
        if (bad_c == 0) begin ac = c; ec = 32'(k % (m + 1)); end
        bad_c++;
      end
      if (nmi_n !== !model_low(k, m, en)) begin
        if (bad_n == 0) begin an = nmi_n; en_exp = !model_low(k, m, en); end
        bad_n++;
      end
      if (nmi_req !== (en && (k % (m + 1) == 0))) begin
        if (bad_r == 0) begin ar = nmi_req; er = en && (k % (m + 1) == 0); end
        bad_r++;
      end
    end
    chk(req, "counter sequence (R2)", ac, ec);
    chk(req, "nmi_n sequence (R3)", {31'b0, an}, {31'b0, en_exp});
    chk(req, "nmi_req sequence (R3)", {31'b0, ar}, {31'b0, er});
  endtask

  task automatic stop_and_lock();
    bwrite(3'd0, 16'h0096, 2'b11);
    bwrite(3'd1, 16'h0000, 2'b11);
    bwrite(3'd6, 16'h0001, 2'b01);
    repeat (40) @(negedge clk);
    bwrite(3'd0, 16'h1111, 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] c, c2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 16'h0; bus_be = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "nmi_n", {31'b0, nmi_n}, 32'd1);
    chk("R1", "nmi_req", {31'b0, nmi_req}, 32'd0);
    bread(3'd1, d); chk("R1", "setup", {16'b0, d}, 32'd0);
    rdcnt(c); chk("R1", "count", c, 32'd0);
    bread(3'd2, d); chk("R1", "match lo", {16'b0, d}, 32'd0);

    // R5 locked writes ignored, R11 counter stopped
    bwrite(3'd2, 16'h1234, 2'b11);
    bread(3'd2, d); chk("R5", "locked match lo", {16'b0, d}, 32'd0);
    bwrite(3'd1, 16'h0003, 2'b11);
    bread(3'd1, d); chk("R5", "locked setup", {16'b0, d}, 32'd0);
    repeat (5) @(negedge clk);
    rdcnt(c); chk("R11", "stopped count", c, 32'd0);

    // R6 byte-wide key write ignored, key reads zero
    bwrite(3'd0, 16'h0096, 2'b01);
    bwrite(3'd2, 16'h1234, 2'b11);
    bread(3'd2, d); chk("R6", "byte key no unlock", {16'b0, d}, 32'd0);
    bread(3'd0, d); chk("R6", "key read", {16'b0, d}, 32'd0);

    // R4 unlock persists
    bwrite(3'd0, 16'h0096, 2'b11);
    bread(3'd0, d); chk("R6", "key read unlocked", {16'b0, d}, 32'd0);
    bwrite(3'd2, 16'h1234, 2'b11);
    bread(3'd2, d); chk("R4", "unlocked match lo", {16'b0, d}, 32'h1234);
    bwrite(3'd3, 16'h00AB, 2'b11);
    bread(3'd3, d); chk("R4", "unlocked match hi", {16'b0, d}, 32'h00AB);
    bwrite(3'd2, 16'h0005, 2'b11);
    bread(3'd2, d); chk("R4", "still unlocked", {16'b0, d}, 32'h0005);

    // R7 byte strobes
    bwrite(3'd2, 16'hFF77, 2'b01);
    bread(3'd2, d); chk("R7", "low byte only", {16'b0, d}, 32'h0077);
    bwrite(3'd2, 16'h12FF, 2'b10);
    bread(3'd2, d); chk("R7", "high byte only", {16'b0, d}, 32'h1277);
    bwrite(3'd1, 16'h0002, 2'b10);
    bread(3'd1, d); chk("R7", "setup high strobe only", {16'b0, d}, 32'd0);

    // R2 R3 single pulse length, two separated hits
    run_model(100, 1'b1, 250, "R3");
    stop_and_lock();
    // R10 retrigger during pulse
    bwrite(3'd0, 16'h0096, 2'b11);
    run_model(20, 1'b1, 120, "R10");
    stop_and_lock();
    // R9 NMI disabled
    bwrite(3'd0, 16'h0096, 2'b11);
    run_model(5, 1'b0, 60, "R9");
    stop_and_lock();

    // R8 restart, R11 freeze
    bwrite(3'd0, 16'h0096, 2'b11);
    bwrite(3'd2, 16'd1000, 2'b11);
    bwrite(3'd3, 16'h0000, 2'b11);
    bwrite(3'd1, 16'h0001, 2'b11);
    repeat (50) @(negedge clk);
    rdcnt(c); chk("R2", "count after 50", c, 32'd50);
    bwrite(3'd6, 16'h0001, 2'b01);
    rdcnt(c); chk("R8", "restart clears", c, 32'd0);
    @(negedge clk);
    rdcnt(c); chk("R8", "counts after restart", c, 32'd1);
    bwrite(3'd1, 16'h0000, 2'b11);
    rdcnt(c);
    repeat (5) @(negedge clk);
    rdcnt(c2); chk("R11", "frozen count", c2, c);
    chk("R11", "frozen value", c, 32'd2);
    exp_match = 32'd1000;

    // R4 relock with other key, R5
    bwrite(3'd0, 16'h0097, 2'b11);
    bwrite(3'd2, 16'h0007, 2'b11);
    bread(3'd2, d); chk("R5", "relocked match lo", {16'b0, d}, 32'd1000);
    bwrite(3'd6, 16'h0001, 2'b01);

    // constrained random sequences
    for (int it = 0; it < 20; it++) begin
      logic [15:0] key;
      int m;
      bit en;
      key = ($urandom % 2 == 0) ? 16'h0096 : 16'($urandom);
      if (key == 16'h0096 && it % 5 == 4) key = 16'h0095;
      m = 10 + int'($urandom % 50);
      en = 1'($urandom % 2);
      bwrite(3'd0, key, 2'b11);
      if (key == 16'h0096) begin
        run_model(m, en, 3 * (m + 1) + 35, en ? "R3" : "R9");
        exp_match = 32'(m);
      end else begin
        bwrite(3'd2, m[15:0], 2'b11);
        bwrite(3'd1, {14'b0, en, 1'b1}, 2'b11);
        repeat (20) @(negedge clk);
        rdcnt(c); chk("R5", "locked random count", c, 32'd0);
        bread(3'd2, d); chk("R5", "locked random match", {16'b0, d}, {16'b0, exp_match[15:0]});
        chk("R5", "locked random nmi_n", {31'b0, nmi_n}, 32'd1);
      end
      stop_and_lock();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule